// File: doc/BRIEF.md
# Byte-Masked Page Buffer Controller

This block holds one page of pending program data in front of three nonvolatile arrays: flash, EEPROM and a single user-row page that is written exactly like EEPROM. Since all three share the one buffer, only one section can be staged at a time. The first byte written after the buffer is empty claims it for that section and page. Every byte position has a marker that is set when the bus writes that position, so the later commit touches only the bytes that software actually wrote.

A commit command drains the buffer. It takes the marked bytes in ascending position order and gives each one a fixed number of cycles on the array write port, which stands in for the erase-and-program time of a cell. While a commit is running, the controller holds any array read with a bus wait. When the commit finishes, or when a clear command arrives, all markers are dropped and the buffer is free for any section again.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset, busy, arr_we, sec_err and bus_wait are all low and the buffer holds no marked bytes.
- R2: A bus write that is accepted stores bus_wdata at position bus_addr[PB_W-1:0] and marks that position. Writing the same position again replaces the stored value, and the last value written is the one committed.
- R3: A commit presents each marked byte exactly once on the array port, in ascending position order. arr_addr is {latched page, position} and arr_wdata is the stored byte. Unmarked positions are never presented.
- R4: busy rises in the cycle after the commit is sampled and stays high for N*CYC_PER_BYTE cycles, where N is the number of marked bytes. arr_we is high only in the first cycle of each byte's slot.
- R5: A commit with no marked bytes holds busy high for exactly one cycle and never raises arr_we.
- R6: The first accepted write on an empty buffer latches the section code (0 flash, 1 EEPROM, 2 user row) and the page bus_addr[ADDR_W-1:PB_W]. arr_sec then carries that code. Later writes with the same section code but a different page land in the latched page at their own position. A write with a different section code is dropped, and sec_err is high for one cycle in the cycle after it.
- R7: bus_wait is high in any cycle where bus_rd is high while busy is high. It is low whenever busy is low.
- R8: When a commit ends, and on an accepted clear command, all markers and the section claim are released. When idle, clear takes precedence over a write and a commit in the same cycle, and both of those are dropped.
- R9: While busy, bus writes, commit and clear commands are ignored and raise no sec_err. The running commit continues to its end.
- R10: A write and a commit sampled in the same idle cycle are both taken, and the written byte is part of that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write one byte into the page buffer |
| bus_rd | input | 1 | Read request towards the arrays |
| bus_sec | input | 2 | Section code of the bus access |
| bus_addr | input | ADDR_W | Byte address in the section |
| bus_wdata | input | 8 | Write data |
| cmd_commit | input | 1 | Start draining the buffer into the array |
| cmd_clear | input | 1 | Drop all markers and the section claim |
| bus_wait | output | 1 | Stall for the pending read |
| sec_err | output | 1 | One-cycle flag for a dropped cross-section write |
| busy | output | 1 | Commit in progress |
| arr_we | output | 1 | Array byte erase/write strobe |
| arr_sec | output | 2 | Target section of the array access |
| arr_addr | output | ADDR_W | Target byte address |
| arr_wdata | output | 8 | Target byte value |

## Verification
Two kinds of same-cycle collision are provoked directly. The first drives a write together with a commit on an idle buffer, and also a write together with a clear. The result is judged on what the following commit puts on the array port: the extra byte is present in the first case, and nothing is written in the second. The second kind drives read, write, clear and commit while a commit is draining. Here the bench expects bus_wait in the read cycle, an unchanged drain length and address sequence, and an empty buffer on the next commit. A behavioural model in the bench predicts every output in every cycle, and each difference is reported against the requirement that owns it.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    SEC_FLASH  = 2'd0,
    SEC_EEPROM = 2'd1,
    SEC_UROW   = 2'd2,
    SEC_RSVD   = 2'd3
  } sec_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_NOP  = 2'd1,
    SQ_RUN  = 2'd2
  } seq_e;
endpackage

// File: rtl/pgbuf_owner.sv
module pgbuf_owner
  import pgbuf_pkg::*;
#(
  parameter int PG_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_wr,
  input  logic            release_i,
  input  sec_e            wr_sec,
  input  logic [PG_W-1:0] wr_page,
  output logic            accept,
  output logic            owned,
  output sec_e            cur_sec,
  output logic [PG_W-1:0] cur_page,
  output logic            err_q
);
  logic mismatch;

  always_comb begin
    mismatch = take_wr && owned && (wr_sec != cur_sec);
    accept   = take_wr && !mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned    <= 1'b0;
      cur_sec  <= SEC_FLASH;
      cur_page <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= mismatch;
      if (release_i) begin
        owned <= 1'b0;
      end else if (accept && !owned) begin
        owned    <= 1'b1;
        cur_sec  <= wr_sec;
        cur_page <= wr_page;
      end
    end
  end
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int PAGE_BYTES = 8,
  parameter int DW         = 8,
  localparam int PB_W      = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PB_W-1:0]       wr_pos,
  input  logic [DW-1:0]         wr_data,
  input  logic                  clr,
  input  logic [PB_W-1:0]       rd_pos,
  output logic [PAGE_BYTES-1:0] mask_q,
  output logic [PAGE_BYTES-1:0] mask_eff,
  output logic [DW-1:0]         rd_data
);
  logic          mark_a [PAGE_BYTES];
  logic [DW-1:0] data_a [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] hit;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    assign hit[g] = wr_en && (wr_pos == PB_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mark_a[g] <= 1'b0;
        data_a[g] <= '0;
      end else begin
        if (clr)         mark_a[g] <= 1'b0;
        else if (hit[g]) mark_a[g] <= 1'b1;
        if (hit[g])      data_a[g] <= wr_data;
      end
    end

    assign mask_q[g] = mark_a[g];
  end

  assign mask_eff = mask_q | hit;
  assign rd_data  = data_a[rd_pos];
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES   = 8,
  parameter int CYC_PER_BYTE = 3,
  localparam int PB_W  = $clog2(PAGE_BYTES),
  localparam int CNT_W = (CYC_PER_BYTE > 1) ? $clog2(CYC_PER_BYTE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAGE_BYTES-1:0] mask_in,
  output logic                  busy,
  output logic                  we,
  output logic [PB_W-1:0]       pos,
  output logic                  done
);
  seq_e                  state;
  logic [PAGE_BYTES-1:0] pend;
  logic [PAGE_BYTES-1:0] rest;
  logic [CNT_W-1:0]      cnt;
  logic                  slot_end;

  function automatic logic [PB_W-1:0] lowest_set(input logic [PAGE_BYTES-1:0] m);
    logic [PB_W-1:0] r;
    r = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (m[i]) r = PB_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    rest     = pend & ~(PAGE_BYTES'(1) << pos);
    slot_end = (state == SQ_RUN) && (cnt == CNT_W'(CYC_PER_BYTE - 1));
    busy     = (state != SQ_IDLE);
    we       = (state == SQ_RUN) && (cnt == '0);
    done     = (state == SQ_NOP) || (slot_end && (rest == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      pend  <= '0;
      pos   <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            if (mask_in == '0) begin
              state <= SQ_NOP;
            end else begin
              state <= SQ_RUN;
              pend  <= mask_in;
              pos   <= lowest_set(mask_in);
              cnt   <= '0;
            end
          end
        end
        SQ_NOP: state <= SQ_IDLE;
        SQ_RUN: begin
          if (slot_end) begin
            pend <= rest;
            cnt  <= '0;
            if (rest == '0) state <= SQ_IDLE;
            else            pos   <= lowest_set(rest);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int PAGE_BYTES   = 8,
  parameter int CYC_PER_BYTE = 3,
  localparam int PB_W = $clog2(PAGE_BYTES),
  localparam int PG_W = ADDR_W - PB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sec,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              cmd_commit,
  input  logic              cmd_clear,
  output logic              bus_wait,
  output logic              sec_err,
  output logic              busy,
  output logic              arr_we,
  output logic [1:0]        arr_sec,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  logic                  idle;
  logic                  clear_take;
  logic                  wr_take;
  logic                  start_w;
  logic                  empty_w;
  logic                  wr_accept;
  logic                  owned;
  logic                  seq_done;
  logic                  release_w;
  sec_e                  cur_sec;
  logic [PG_W-1:0]       cur_page;
  logic [PB_W-1:0]       seq_pos;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_BYTES-1:0] mask_eff;
  logic [7:0]            rd_byte;

  assign idle       = !busy;
  assign clear_take = cmd_clear && idle;
  assign wr_take    = bus_wr && idle && !cmd_clear;
  assign start_w    = cmd_commit && idle && !cmd_clear;
  assign empty_w    = start_w && (mask_eff == '0);
  assign release_w  = clear_take || seq_done;

  pgbuf_owner #(.PG_W(PG_W)) u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_wr   (wr_take),
    .release_i (release_w),
    .wr_sec    (sec_e'(bus_sec)),
    .wr_page   (bus_addr[ADDR_W-1:PB_W]),
    .accept    (wr_accept),
    .owned     (owned),
    .cur_sec   (cur_sec),
    .cur_page  (cur_page),
    .err_q     (sec_err)
  );

  pgbuf_store #(.PAGE_BYTES(PAGE_BYTES), .DW(8)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_accept),
    .wr_pos   (bus_addr[PB_W-1:0]),
    .wr_data  (bus_wdata),
    .clr      (release_w),
    .rd_pos   (seq_pos),
    .mask_q   (mask_q),
    .mask_eff (mask_eff),
    .rd_data  (rd_byte)
  );

  pgbuf_seq #(.PAGE_BYTES(PAGE_BYTES), .CYC_PER_BYTE(CYC_PER_BYTE)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_w),
    .mask_in (mask_eff),
    .busy    (busy),
    .we      (arr_we),
    .pos     (seq_pos),
    .done    (seq_done)
  );

  assign bus_wait  = bus_rd && busy;
  assign arr_sec   = cur_sec;
  assign arr_addr  = {cur_page, seq_pos};
  assign arr_wdata = rd_byte;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int ADDR_W       = 10,
  parameter int PB_W         = 3,
  parameter int CYC_PER_BYTE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              bus_rd,
  input logic              bus_wait,
  input logic              sec_err,
  input logic              empty_w,
  input logic              seq_done
);
  logic            have_prev;
  logic [PB_W-1:0] last_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      last_pos  <= '0;
    end else if (!busy) begin
      have_prev <= 1'b0;
    end else if (arr_we) begin
      have_prev <= 1'b1;
      last_pos  <= arr_addr[PB_W-1:0];
    end
  end

  a_r4_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  a_r4_we_one_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && (CYC_PER_BYTE > 1)) |=> !arr_we);

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && have_prev) |-> (arr_addr[PB_W-1:0] > last_pos));

  a_r5_empty_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    empty_w |=> (busy && !arr_we && seq_done));

  a_r7_wait_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && busy) |-> bus_wait);

  a_r7_no_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_wait);

  a_r9_no_err_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sec_err |-> !$past(busy));
endmodule

bind pgbuf_ctrl pgbuf_chk #(
  .ADDR_W(ADDR_W), .PB_W(PB_W), .CYC_PER_BYTE(CYC_PER_BYTE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .arr_we   (arr_we),
  .arr_addr (arr_addr),
  .bus_rd   (bus_rd),
  .bus_wait (bus_wait),
  .sec_err  (sec_err),
  .empty_w  (empty_w),
  .seq_done (seq_done)
);

// File: tb/sim_pgbuf_ctrl.sv
module sim_pgbuf_ctrl;
  localparam int ADDR_W = 10;
  localparam int PAGE   = 8;
  localparam int PB_W   = 3;
  localparam int CYC    = 3;

  logic              clk, rst_n;
  logic              bus_wr, bus_rd, cmd_commit, cmd_clear;
  logic [1:0]        bus_sec;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata;
  logic              bus_wait, sec_err, busy, arr_we;
  logic [1:0]        arr_sec;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0]        arr_wdata;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  pgbuf_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .CYC_PER_BYTE(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sec(bus_sec), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cmd_commit(cmd_commit), .cmd_clear(cmd_clear), .bus_wait(bus_wait),
    .sec_err(sec_err), .busy(busy), .arr_we(arr_we), .arr_sec(arr_sec),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model state
  bit  m_mark [PAGE];
  int  m_data [PAGE];
  bit  m_own;
  int  m_sec, m_page, m_left, m_slot;
  bit  m_empty, m_err;
  int  q_addr [$];
  int  q_data [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mark[i]) begin m_mark[i] = 0; m_data[i] = 0; end
      m_own = 0; m_sec = 0; m_page = 0; m_left = 0; m_slot = 0;
      m_empty = 0; m_err = 0;
    end else begin
      m_err = 0;
      if (m_left > 0) begin
        m_left--;
        m_slot++;
      end else if (cmd_clear) begin
        foreach (m_mark[i]) m_mark[i] = 0;
        m_own = 0;
      end else begin
        if (bus_wr) begin
          if (!m_own) begin
            m_own = 1; m_sec = bus_sec; m_page = int'(bus_addr) / PAGE;
          end
          if (int'(bus_sec) == m_sec) begin
            m_mark[int'(bus_addr) % PAGE] = 1;
            m_data[int'(bus_addr) % PAGE] = bus_wdata;
          end else m_err = 1;
        end
        if (cmd_commit) begin
          q_addr.delete(); q_data.delete();
          for (int i = 0; i < PAGE; i++) if (m_mark[i]) begin
            q_addr.push_back(m_page * PAGE + i);
            q_data.push_back(m_data[i]);
          end
          m_slot  = 0;
          m_empty = (q_addr.size() == 0);
          m_left  = m_empty ? 1 : q_addr.size() * CYC;
          foreach (m_mark[i]) m_mark[i] = 0;
          m_own = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit e_busy, e_we;
      e_busy = (m_left > 0);
      e_we   = e_busy && !m_empty && (m_slot % CYC == 0);
      check(busy == e_busy, "R4 busy", busy, e_busy);
      check(arr_we == e_we, "R3 arr_we", arr_we, e_we);
      check(sec_err == m_err, "R6 sec_err", sec_err, m_err);
      check(bus_wait == (bus_rd && e_busy), "R7 bus_wait", bus_wait, bus_rd && e_busy);
      if (e_we && arr_we) begin
        check(int'(arr_addr) == q_addr[m_slot / CYC], "R3 arr_addr", arr_addr, q_addr[m_slot / CYC]);
        check(int'(arr_wdata) == q_data[m_slot / CYC], "R2 arr_wdata", arr_wdata, q_data[m_slot / CYC]);
        check(int'(arr_sec) == m_sec, "R6 arr_sec", arr_sec, m_sec);
      end
    end
  end

  task automatic step(input bit w, input int s, input int a, input int d,
                      input bit c, input bit cl, input bit r);
    @(posedge clk); #2;
    bus_wr = w; bus_sec = 2'(s); bus_addr = ADDR_W'(a); bus_wdata = 8'(d);
    cmd_commit = c; cmd_clear = cl; bus_rd = r;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int s, input int a, input int d);
    step(1, s, a, d, 0, 0, 0);
  endtask

  task automatic drain(output int len, output int wes);
    bit go = 1;
    idle();
    len = 0; wes = 0;
    while (go) begin
      @(negedge clk);
      if (busy) begin len++; wes += int'(arr_we); end
      else go = 0;
    end
  endtask

  task automatic commit_measure(output int len, output int wes);
    step(0, 0, 0, 0, 1, 0, 0);
    drain(len, wes);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len, wes;
    bit err_seen;
    rst_n = 0; bus_wr = 0; bus_rd = 0; cmd_commit = 0; cmd_clear = 0;
    bus_sec = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !arr_we && !sec_err && !bus_wait, "R1 reset outputs", {busy, arr_we, sec_err, bus_wait}, 0);
    commit_measure(len, wes);
    check(wes == 0, "R1 no marks after reset", wes, 0);

    // R2 R3 R4: EEPROM page 3, unordered writes with an overwrite
    wr(1, 3*8+5, 'hA5); wr(1, 3*8+2, 'h3C); wr(1, 3*8+7, 'h77); wr(1, 3*8+5, 'h5A);
    commit_measure(len, wes);
    check(len == 9, "R4 busy length", len, 9);
    check(wes == 3, "R3 write count", wes, 3);

    // R5 empty commit
    commit_measure(len, wes);
    check(len == 1, "R5 empty busy", len, 1);
    check(wes == 0, "R5 empty no write", wes, 0);

    // R6 cross-section write dropped and flagged
    wr(0, 1*8+0, 'h11);
    wr(2, 1*8+3, 'h22);
    idle();
    @(negedge clk);
    err_seen = sec_err;
    check(err_seen, "R6 sec_err raised", err_seen, 1);
    commit_measure(len, wes);
    check(wes == 1, "R6 foreign byte dropped", wes, 1);

    // R6 same section, other page lands in latched page
    wr(1, 2*8+1, 'h31); wr(1, 5*8+4, 'h34);
    commit_measure(len, wes);
    check(wes == 2, "R6 page latch", wes, 2);

    // R8 clear command
    wr(2, 9*8+1, 'h01); wr(2, 9*8+6, 'h06);
    step(0, 0, 0, 0, 0, 1, 0);
    commit_measure(len, wes);
    check(wes == 0 && len == 1, "R8 clear drops marks", wes, 0);

    // R8 clear beats write and commit in same cycle
    step(1, 1, 4*8+2, 'h99, 1, 1, 0);
    idle();
    @(negedge clk);
    check(!busy, "R8 clear beats commit", busy, 0);
    commit_measure(len, wes);
    check(wes == 0, "R8 clear beats write", wes, 0);

    // R10 write together with commit
    step(1, 0, 6*8+3, 'h63, 1, 0, 0);
    drain(len, wes);
    check(wes == 1 && len == 3, "R10 same-cycle write committed", wes, 1);

    // R9 R7 activity during busy
    wr(0, 7*8+1, 'h71); wr(0, 7*8+6, 'h76);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    check(bus_wait, "R7 wait during busy", bus_wait, 1);
    step(1, 2, 7*8+2, 'hEE, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    drain(len, wes);
    check(len == 2, "R9 commit not cut short", len, 2);
    commit_measure(len, wes);
    check(wes == 0 && len == 1, "R9 busy write ignored", wes, 0);

    // R7 idle read no wait
    step(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    check(!bus_wait, "R7 idle read", bus_wait, 0);
    idle();

    // R3 R4 full page, reverse order writes, user row
    for (int i = PAGE - 1; i >= 0; i--) wr(2, 12*8+i, 'hC0 + i);
    commit_measure(len, wes);
    check(len == PAGE * CYC, "R4 full page length", len, PAGE * CYC);
    check(wes == PAGE, "R3 full page writes", wes, PAGE);

    repeat (3) idle();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule